// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a synchronous host read and write an asynchronous static RAM one word at a time. The host offers a request with a valid/ready handshake. The sequencer then drives the memory pins through a fixed series of phases. These pins are the address, an active-low select, an active-high enable, an active-low write strobe, an active-low output enable, the write data and a flag that turns on the data bus driver. Each phase lasts a whole number of clock cycles.

The memory's timing figures are given in nanoseconds, and the parameters take them in that form. At elaboration each figure is rounded up to whole cycles of the host clock. The defaults are a 30 ns write pulse, 5 ns write recovery, 40 ns read access and a 5 ns clock. With these defaults a write pulse lasts 6 cycles, recovery lasts 1 cycle and a read access lasts 8 cycles. Address setup and hold are given directly as cycle counts, and both default to 1.

A write runs through setup, pulse, hold and recovery. A read runs through access and recovery. During recovery the memory is deselected. The host gets a one-cycle acknowledge when the memory phases of a request are over. For a read, the captured data and its one-cycle valid strobe come in the same cycle as the acknowledge. A new request is taken only once recovery has expired.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, the pins are in these states: select high, enable low, write strobe high, output enable high, bus driver off. Ready is 1, and acknowledge and read-valid are 0.
- R2: A write holds the write strobe low for exactly ceil(WR_PULSE_NS/CLK_NS) consecutive cycles. Select is low and enable is high in every one of those cycles.
- R3: A write first drives the address and the data (bus driver on) with select low for SETUP_CYC cycles with the strobe high. Address and data then stay unchanged through the whole pulse. After the strobe rises, address and data are held with select low for HOLD_CYC more cycles.
- R4: After every access, select is high and enable is low for ceil(WR_REC_NS/CLK_NS) cycles before the memory is selected again. The write strobe is high between any two writes.
- R5: A read holds select low, enable high, write strobe high and output enable low for exactly ceil(RD_ACC_NS/CLK_NS) consecutive cycles. The bus driver is off during those cycles and the read address stays constant.
- R6: The bus driver and a low output enable never occur in the same cycle. Output enable falls only after a cycle in which the bus driver was off and the write strobe was high.
- R7: Read data is the value on the memory data input in the last access cycle. It appears on rdata_o together with a one-cycle rdata_valid_o pulse in the following cycle.
- R8: Each accepted request produces exactly one one-cycle ack_o pulse, in the first recovery cycle.
- R9: A request is accepted at a clock edge where req_valid_i and req_ready_o are both 1. Ready is 1 only in idle. A request offered while ready is 0 leaves the pins and the memory contents unchanged. Back-to-back requests keep the phase lengths above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Sequencer idle and able to take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| ack_o | output | 1 | One-cycle pulse when a request completes |
| rdata_o | output | DATA_W | Captured read data |
| rdata_valid_o | output | 1 | One-cycle strobe for rdata_o |
| sram_addr_o | output | ADDR_W | Memory address pins |
| sram_cs_n_o | output | 1 | Memory select, active low |
| sram_ce_o | output | 1 | Memory enable, active high |
| sram_we_n_o | output | 1 | Write strobe, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_dq_o | output | DATA_W | Data driven toward the memory |
| sram_dq_oe_o | output | 1 | Bus driver on |
| sram_dq_i | input | DATA_W | Data returned by the memory |

## Verification
The bench compares the pins in every cycle of a request against a phase schedule that it derives from the nanosecond parameters. An off-by-one in the cycle rounding or in the counter reload would show up as a write pulse or read window one cycle short or long. A memory model latches data on the rising write strobe, and every written word is read back, so a write with the address or data released too early would store the wrong word. A request offered while the sequencer is busy is then read back from its target address; a sequencer that wrongly accepted it would have stored 0xFF there. The bench also pairs writes and reads back to back across the address extremes. A sequencer that skipped recovery or turned on output enable while still driving the bus would break the recovery length or the contention count.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_RECOV
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ce;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } pin_ctl_t;

  // ns figure to whole cycles, never below one
  function automatic int unsigned cyc_of(input int unsigned ns, input int unsigned clk_ns);
    int unsigned r;
    r = (ns + clk_ns - 1) / clk_ns;
    return (r == 0) ? 1 : r;
  endfunction

  function automatic pin_ctl_t pins_for(input seq_state_e s);
    pin_ctl_t p;
    p = '{cs_n: 1'b1, ce: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
    case (s)
      ST_WSETUP, ST_WHOLD: p = '{cs_n: 1'b0, ce: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
      ST_WPULSE:           p = '{cs_n: 1'b0, ce: 1'b1, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
      ST_RACC:             p = '{cs_n: 1'b0, ce: 1'b1, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
      default:             ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_rcap.sv
module sram_seq_rcap #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) rdata_o <= dq_i;
    end
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CLK_NS      = 5,
  parameter int unsigned WR_PULSE_NS = 30,
  parameter int unsigned WR_REC_NS   = 5,
  parameter int unsigned RD_ACC_NS   = 40,
  parameter int unsigned SETUP_CYC   = 1,
  parameter int unsigned HOLD_CYC    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_cs_n_o,
  output logic              sram_ce_o,
  output logic              sram_we_n_o,
  output logic              sram_oe_n_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int unsigned PULSE_CYC = cyc_of(WR_PULSE_NS, CLK_NS);
  localparam int unsigned REC_CYC   = cyc_of(WR_REC_NS, CLK_NS);
  localparam int unsigned ACC_CYC   = cyc_of(RD_ACC_NS, CLK_NS);
  localparam int unsigned SU_CYC    = (SETUP_CYC == 0) ? 1 : SETUP_CYC;
  localparam int unsigned HO_CYC    = (HOLD_CYC == 0) ? 1 : HOLD_CYC;
  localparam int unsigned MAX_A     = (PULSE_CYC > ACC_CYC) ? PULSE_CYC : ACC_CYC;
  localparam int unsigned MAX_B     = (SU_CYC > HO_CYC) ? SU_CYC : HO_CYC;
  localparam int unsigned MAX_C     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_CYC   = (MAX_C > REC_CYC) ? MAX_C : REC_CYC;
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  seq_state_e state_q, state_d;
  pin_ctl_t   pins_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept, done, op_end, cap, ack_q;
  logic [CNT_W-1:0]  load_val;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    state_d = state_q;
    op_end  = 1'b0;
    cap     = 1'b0;
    case (state_q)
      ST_IDLE:   if (accept) state_d = req_we_i ? ST_WSETUP : ST_RACC;
      ST_WSETUP: if (done) state_d = ST_WPULSE;
      ST_WPULSE: if (done) state_d = ST_WHOLD;
      ST_WHOLD:  if (done) begin state_d = ST_RECOV; op_end = 1'b1; end
      ST_RACC:   if (done) begin state_d = ST_RECOV; op_end = 1'b1; cap = 1'b1; end
      ST_RECOV:  if (done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // phase length minus one, reloaded on every phase change
  always_comb begin
    case (state_d)
      ST_WSETUP: load_val = CNT_W'(SU_CYC - 1);
      ST_WPULSE: load_val = CNT_W'(PULSE_CYC - 1);
      ST_WHOLD:  load_val = CNT_W'(HO_CYC - 1);
      ST_RACC:   load_val = CNT_W'(ACC_CYC - 1);
      ST_RECOV:  load_val = CNT_W'(REC_CYC - 1);
      default:   load_val = '0;
    endcase
  end

  sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (state_d != state_q),
    .load_val_i (load_val),
    .done_o     (done)
  );

  sram_seq_rcap #(.DATA_W(DATA_W)) u_rcap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .dq_i    (sram_dq_i),
    .rdata_o (rdata_o),
    .valid_o (rdata_valid_o)
  );

  // pins registered from next state: glitch-free strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pins_q  <= pins_for(ST_IDLE);
      addr_q  <= '0;
      wdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pins_q  <= pins_for(state_d);
      ack_q   <= op_end;
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  assign ack_o        = ack_q;
  assign sram_addr_o  = addr_q;
  assign sram_dq_o    = wdata_q;
  assign sram_cs_n_o  = pins_q.cs_n;
  assign sram_ce_o    = pins_q.ce;
  assign sram_we_n_o  = pins_q.we_n;
  assign sram_oe_n_o  = pins_q.oe_n;
  assign sram_dq_oe_o = pins_q.dq_oe;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned CLK_NS      = 5,
  parameter int unsigned WR_PULSE_NS = 30,
  parameter int unsigned WR_REC_NS   = 5,
  parameter int unsigned RD_ACC_NS   = 40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              ack_o,
  input logic              rdata_valid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_cs_n_o,
  input logic              sram_ce_o,
  input logic              sram_we_n_o,
  input logic              sram_oe_n_o,
  input logic              sram_dq_oe_o
);
  localparam int unsigned PULSE_CYC = cyc_of(WR_PULSE_NS, CLK_NS);
  localparam int unsigned REC_CYC   = cyc_of(WR_REC_NS, CLK_NS);
  localparam int unsigned ACC_CYC   = cyc_of(RD_ACC_NS, CLK_NS);

  logic [7:0] wl_cnt, ol_cnt, ds_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wl_cnt <= '0;
      ol_cnt <= '0;
      ds_cnt <= '1;
    end else begin
      wl_cnt <= sram_we_n_o ? 8'd0 : ((wl_cnt == 8'hFF) ? wl_cnt : wl_cnt + 8'd1);
      ol_cnt <= sram_oe_n_o ? 8'd0 : ((ol_cnt == 8'hFF) ? ol_cnt : ol_cnt + 8'd1);
      ds_cnt <= !sram_cs_n_o ? 8'd0 : ((ds_cnt == 8'hFF) ? ds_cnt : ds_cnt + 8'd1);
    end
  end

  p_we_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |-> (!sram_cs_n_o && sram_ce_o));
  p_pulse_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_n_o) |-> (wl_cnt == 8'(PULSE_CYC)));
  p_addr_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_n_o && $past(!sram_we_n_o)) |-> $stable(sram_addr_o));
  p_data_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |-> sram_dq_oe_o);
  p_recov_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_cs_n_o) |-> (ds_cnt >= 8'(REC_CYC)));
  p_read_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_n_o |-> (!sram_cs_n_o && sram_ce_o && sram_we_n_o));
  p_acc_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_oe_n_o) |-> (ol_cnt == 8'(ACC_CYC)));
  p_no_fight_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_dq_oe_o && !sram_oe_n_o));
  p_oe_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_oe_n_o) |-> ($past(!sram_dq_oe_o) && $past(sram_we_n_o)));
  p_rv_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> ack_o);
  p_ack_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  p_ready_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sram_cs_n_o && !ack_o));
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
  .ADDR_W      (ADDR_W),
  .CLK_NS      (CLK_NS),
  .WR_PULSE_NS (WR_PULSE_NS),
  .WR_REC_NS   (WR_REC_NS),
  .RD_ACC_NS   (RD_ACC_NS)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_ready_o   (req_ready_o),
  .ack_o         (ack_o),
  .rdata_valid_o (rdata_valid_o),
  .sram_addr_o   (sram_addr_o),
  .sram_cs_n_o   (sram_cs_n_o),
  .sram_ce_o     (sram_ce_o),
  .sram_we_n_o   (sram_we_n_o),
  .sram_oe_n_o   (sram_oe_n_o),
  .sram_dq_oe_o  (sram_dq_oe_o)
);

// File: tb/sram_seq_ctrl_tb.sv
module sram_seq_ctrl_tb;
  localparam int AW = 15;
  localparam int DW = 8;
  // phase lengths worked out from the ns figures: ceil(ns / 5)
  localparam int SU = 1;
  localparam int PW = (30 + 4) / 5;
  localparam int HO = 1;
  localparam int RC = (5 + 4) / 5;
  localparam int AC = (40 + 4) / 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, ack, rvalid;
  logic [DW-1:0] rdata;
  logic [AW-1:0] s_addr;
  logic s_cs_n, s_ce, s_we_n, s_oe_n, s_dq_oe;
  logic [DW-1:0] s_dq_o, s_dq_i;

  int checks = 0, fails = 0, fights = 0, cyc = 0;
  logic [DW-1:0] mem [logic [AW-1:0]];
  logic [DW-1:0] shadow [logic [AW-1:0]];

  always #2.5 clk = ~clk;

  sram_seq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .ack_o(ack), .rdata_o(rdata), .rdata_valid_o(rvalid),
    .sram_addr_o(s_addr), .sram_cs_n_o(s_cs_n), .sram_ce_o(s_ce),
    .sram_we_n_o(s_we_n), .sram_oe_n_o(s_oe_n), .sram_dq_o(s_dq_o),
    .sram_dq_oe_o(s_dq_oe), .sram_dq_i(s_dq_i)
  );

  function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // memory model: latches on the rising write strobe
  always @(posedge s_we_n)
    if (s_cs_n === 1'b0 && s_ce === 1'b1) mem[s_addr] = s_dq_o;

  always_comb begin
    if (!s_cs_n && s_ce && s_we_n && !s_oe_n)
      s_dq_i = mem.exists(s_addr) ? mem[s_addr] : init_val(s_addr);
    else
      s_dq_i = 8'h00;
  end

  always @(negedge clk) if (rst_n && s_dq_oe && !s_oe_n) fights++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // {cs_n, ce, we_n, oe_n, dq_oe, ack, rvalid, ready}
  function automatic logic [7:0] exp_vec(input bit we, input int k, output string req);
    if (we) begin
      if (k <= SU)                begin req = "R3"; return 8'b0111_1000; end
      if (k <= SU + PW)           begin req = "R2"; return 8'b0101_1000; end
      if (k <= SU + PW + HO)      begin req = "R3"; return 8'b0111_1000; end
      if (k <= SU + PW + HO + RC) begin req = "R4";
        return (k == SU + PW + HO + 1) ? 8'b1011_0100 : 8'b1011_0000; end
    end else begin
      if (k <= AC)                begin req = "R5"; return 8'b0110_0000; end
      if (k <= AC + RC)           begin req = "R4";
        return (k == AC + 1) ? 8'b1011_0110 : 8'b1011_0000; end
    end
    req = "R9";
    return 8'b1011_0001;
  endfunction

  // called at a negedge with ready high; returns at the negedge of the first idle cycle
  task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
    int total;
    string req;
    logic [7:0] e, got;
    logic [DW-1:0] expd;
    total = we ? (SU + PW + HO + RC + 1) : (AC + RC + 1);
    expd  = shadow.exists(a) ? shadow[a] : init_val(a);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1 req_valid = 1'b0;
    if (we) shadow[a] = d;
    for (int k = 1; k <= total; k++) begin
      @(negedge clk);
      if (poke && k == 3) begin
        req_valid = 1'b1; req_we = 1'b1; req_addr = 15'h0BBB; req_wdata = 8'hFF;
      end
      if (poke && k == 5) req_valid = 1'b0;
      e = exp_vec(we, k, req);
      got = {s_cs_n, s_ce, s_we_n, s_oe_n, s_dq_oe, ack, rvalid, req_ready};
      chk(got == e, req, $sformatf("pins k=%0d we=%0b", k, we), 32'(got), 32'(e));
      if (k <= total - RC - 1)
        chk(s_addr == a, we ? "R3" : "R5", "address held", 32'(s_addr), 32'(a));
      if (we && k <= SU + PW + HO)
        chk(s_dq_o == d, "R3", "write data held", 32'(s_dq_o), 32'(d));
      if (!we && k == AC + 1)
        chk(rdata == expd, "R7", "read data", 32'(rdata), 32'(expd));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R9 watchdog actual=%0d expected<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({s_cs_n, s_ce, s_we_n, s_oe_n, s_dq_oe, ack, rvalid, req_ready} == 8'b1011_0001,
        "R1", "pins in reset", 32'({s_cs_n, s_ce, s_we_n, s_oe_n, s_dq_oe, ack, rvalid, req_ready}), 32'hB1);
    rst_n = 1'b1;
    @(negedge clk);
    chk({s_cs_n, s_ce, s_we_n, s_oe_n, s_dq_oe, ack, rvalid, req_ready} == 8'b1011_0001,
        "R1", "pins after reset", 32'({s_cs_n, s_ce, s_we_n, s_oe_n, s_dq_oe, ack, rvalid, req_ready}), 32'hB1);

    // R9 back-to-back write then read across the address range, ends included
    for (int i = 0; i < 24; i++) begin
      a = (i == 0) ? 15'h0000 : (i == 1) ? 15'h7FFF : 15'((i * 1367) & 32'h7FFF);
      d = (i == 2) ? 8'hFF : (i == 3) ? 8'h00 : (a[7:0] ^ 8'h3C ^ 8'(i));
      do_op(1'b1, a, d, 1'b0);
      do_op(1'b0, a, 8'h00, 1'b0);
    end
    // second pass: reads back to back, data still in place
    for (int i = 0; i < 24; i++) begin
      a = (i == 0) ? 15'h0000 : (i == 1) ? 15'h7FFF : 15'((i * 1367) & 32'h7FFF);
      do_op(1'b0, a, 8'h00, 1'b0);
    end
    // unwritten location returns preload
    do_op(1'b0, 15'h1234, 8'h00, 1'b0);
    // R9 request offered while busy must be ignored
    do_op(1'b1, 15'h0AAA, 8'h81, 1'b1);
    do_op(1'b0, 15'h0BBB, 8'h00, 1'b0);
    do_op(1'b0, 15'h0AAA, 8'h00, 1'b0);
    // write-after-write to one address, last write wins
    do_op(1'b1, 15'h0AAA, 8'h18, 1'b0);
    do_op(1'b1, 15'h0AAA, 8'hE7, 1'b0);
    do_op(1'b0, 15'h0AAA, 8'h00, 1'b0);

    chk(fights == 0, "R6", "bus driver with output enable", 32'(fights), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule